// File: doc/BRIEF.md
# Two-Port Shared Memory Contention Arbiter

This block sits beside a memory that two independent ports share. Each port brings an active-low select, a 13-bit word address and an active-low write strobe. When both ports are selected and point at the same word, the block decides which of them got there first. The port that was first keeps its access. The other port receives an active-low BUSY flag and loses permission to write. A port that is BUSY may still read, because only its write permit is withdrawn.

A mode strap picks one of two roles, so that several of these blocks can be placed side by side to widen the data word. In master mode the block arbitrates and drives its BUSY outputs. In slave mode its BUSY outputs stay inactive. It then takes BUSY from an external master and uses that flag only to hold back the writes of the port that lost. Every output is registered and shows the result one clock after the inputs it depends on.

Top module: `dp_contention_arb`

## Requirements
- R1: While reset is low and in the first cycle after it, both BUSY outputs are high (inactive) and both write permits are low.
- R2: In master mode a BUSY output goes low only in the cycle after one in which both selects were low and the two addresses were equal. At most one of the two BUSY outputs is low in any cycle.
- R3: If a match begins because one port moves its address onto the word of the other port, and the other port was already selected at that word in the previous cycle, then the port that stayed in place wins. The moving port gets BUSY one clock later.
- R4: If a match begins because one port's select falls while the other port was already selected at the same address, then the port that was already selected wins and the late port gets BUSY one clock later.
- R5: BUSY returns high one clock after the addresses stop matching or after either select goes high. While the match persists without a break, the winner keeps its access.
- R6: If both ports arrive at a match in the same cycle, exactly one port wins. The first such tie after reset goes to the left port (r_busy_n low). After that, a tie goes to the right port (l_busy_n low) when the previous tie went to the left, and to the left port otherwise.
- R7: A port's write permit is high one clock after a cycle in which that port's select and write strobe were both low and the port was not the loser of arbitration. Otherwise it is low. Losing does not change the BUSY-free port's permit.
- R8: In slave mode (master_mode low) both BUSY outputs are high. A port's write permit is low one clock after any cycle in which that port's BUSY input was low. The port's write permit depends only on its own BUSY input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| master_mode | input | 1 | 1 = master (BUSY produced here), 0 = slave (BUSY taken from inputs) |
| l_ce_n | input | 1 | Left port select, active low |
| l_addr | input | 13 | Left port word address |
| l_we_n | input | 1 | Left port write strobe, active low |
| l_busy_in_n | input | 1 | Left BUSY from an external master, used in slave mode |
| r_ce_n | input | 1 | Right port select, active low |
| r_addr | input | 13 | Right port word address |
| r_we_n | input | 1 | Right port write strobe, active low |
| r_busy_in_n | input | 1 | Right BUSY from an external master, used in slave mode |
| l_busy_n | output | 1 | Left BUSY, active low, registered |
| r_busy_n | output | 1 | Right BUSY, active low, registered |
| l_wr_ok | output | 1 | Left write permit, registered |
| r_wr_ok | output | 1 | Right write permit, registered |

## Verification
Two of the block's functions can fall in the same cycle. One is the judgement of arrival order, and the other is the write gating that depends on its result. The bench provokes this by starting a match while the losing port is already writing, so that its permit must drop in the same clock as its BUSY. It also makes both ports arrive in one cycle through a simultaneous select fall, and it repeats that tie several times so that the alternation is judged against a behavioural model. On every clock that model predicts all four outputs, and the bench compares them with the design.

// File: rtl/dpca_pkg.sv
// Package: shared types for the two-port contention arbiter.
// Assumes port index 0 is the left port and index 1 is the right port.
package dpca_pkg;
    typedef enum logic [1:0] {
        OWN_NONE  = 2'd0,
        OWN_LEFT  = 2'd1,
        OWN_RIGHT = 2'd2
    } owner_e;
    localparam int NUM_PORTS = 2;
endpackage

// File: rtl/dpca_port_tracker.sv
// Module: dpca_port_tracker
// Remembers one port's select and address from the previous cycle and
// reports whether the port has been parked on its current word since then.
// Assumes a synchronous active-low reset; after reset the port counts as deselected.
module dpca_port_tracker #(
    parameter int ADDR_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic [ADDR_W-1:0] addr,
    output logic              settled
);
    logic              ce_n_q;
    logic [ADDR_W-1:0] addr_q;

    // capture the previous cycle's select and address
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ce_n_q <= 1'b1;
            addr_q <= '0;
        end else begin
            ce_n_q <= ce_n;
            addr_q <= addr;
        end
    end

    // settled: selected now and last cycle, on an unchanged address
    always_comb begin
        settled = !ce_n && !ce_n_q && (addr == addr_q);
    end
endmodule

// File: rtl/dpca_arb_core.sv
// Module: dpca_arb_core
// Decides which port owns a contended word. The port that was settled first
// wins, and an ongoing match keeps its owner. A same-cycle tie alternates, with the
// first tie after reset going to the left port. Produces registered BUSY flags
// (master mode only) and the combinational winner for write gating.
module dpca_arb_core
    import dpca_pkg::*;
#(
    parameter int ADDR_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              master_mode,
    input  logic              l_ce_n,
    input  logic              r_ce_n,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic              l_settled,
    input  logic              r_settled,
    output owner_e            win,
    output logic              l_busy_q,
    output logic              r_busy_q
);
    owner_e owner_q;
    logic   last_tie_left;
    logic   match;
    logic   tie;

    // detect contention and pick the winner for this cycle
    always_comb begin
        match = !l_ce_n && !r_ce_n && (l_addr == r_addr);
        tie   = 1'b0;
        if (!match) begin
            win = OWN_NONE;
        end else if (owner_q != OWN_NONE) begin
            win = owner_q;
        end else if (l_settled && !r_settled) begin
            win = OWN_LEFT;
        end else if (r_settled && !l_settled) begin
            win = OWN_RIGHT;
        end else begin
            tie = 1'b1;
            win = last_tie_left ? OWN_RIGHT : OWN_LEFT;
        end
    end

    // hold the owner, the tie history and the registered BUSY flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            owner_q       <= OWN_NONE;
            last_tie_left <= 1'b0;
            l_busy_q      <= 1'b1;
            r_busy_q      <= 1'b1;
        end else begin
            owner_q <= win;
            if (tie) begin
                last_tie_left <= (win == OWN_LEFT);
            end
            l_busy_q <= !(master_mode && (win == OWN_RIGHT));
            r_busy_q <= !(master_mode && (win == OWN_LEFT));
        end
    end
endmodule

// File: rtl/dpca_wr_gate.sv
// Module: dpca_wr_gate
// Registered write permit for one port. A write request passes unless the
// port lost arbitration: in master mode from the local decision, in slave
// mode from the external BUSY input.
module dpca_wr_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic master_mode,
    input  logic ce_n,
    input  logic we_n,
    input  logic lost_local,
    input  logic busy_in_n,
    output logic wr_ok
);
    logic blocked;

    // choose the source of the loss indication by mode
    always_comb begin
        blocked = master_mode ? lost_local : !busy_in_n;
    end

    // register the write permit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ok <= 1'b0;
        end else begin
            wr_ok <= !ce_n && !we_n && !blocked;
        end
    end
endmodule

// File: rtl/dp_contention_arb.sv
// Module: dp_contention_arb (top)
// Contention arbiter for a two-port shared memory. It tracks both ports,
// arbitrates on address match, drives BUSY in master mode and gates writes
// in both modes. Assumes one synchronous clock domain for both ports.
module dp_contention_arb
    import dpca_pkg::*;
#(
    parameter int ADDR_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              master_mode,
    input  logic              l_ce_n,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic              l_we_n,
    input  logic              l_busy_in_n,
    input  logic              r_ce_n,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic              r_we_n,
    input  logic              r_busy_in_n,
    output logic              l_busy_n,
    output logic              r_busy_n,
    output logic              l_wr_ok,
    output logic              r_wr_ok
);
    logic [NUM_PORTS-1:0]             ce_v;
    logic [NUM_PORTS-1:0]             we_v;
    logic [NUM_PORTS-1:0]             bin_v;
    logic [NUM_PORTS-1:0][ADDR_W-1:0] addr_v;
    logic [NUM_PORTS-1:0]             settled_v;
    logic [NUM_PORTS-1:0]             lost_v;
    logic [NUM_PORTS-1:0]             wr_v;
    owner_e                           win;

    // gather per-port signals into indexed vectors (0 = left, 1 = right)
    always_comb begin
        ce_v   = {r_ce_n, l_ce_n};
        we_v   = {r_we_n, l_we_n};
        bin_v  = {r_busy_in_n, l_busy_in_n};
        addr_v = {r_addr, l_addr};
        lost_v = {win == OWN_LEFT, win == OWN_RIGHT};
    end

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        dpca_port_tracker #(.ADDR_W(ADDR_W)) trk_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .ce_n    (ce_v[p]),
            .addr    (addr_v[p]),
            .settled (settled_v[p])
        );
        dpca_wr_gate gate_i (
            .clk         (clk),
            .rst_n       (rst_n),
            .master_mode (master_mode),
            .ce_n        (ce_v[p]),
            .we_n        (we_v[p]),
            .lost_local  (lost_v[p]),
            .busy_in_n   (bin_v[p]),
            .wr_ok       (wr_v[p])
        );
    end

    dpca_arb_core #(.ADDR_W(ADDR_W)) core_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .master_mode (master_mode),
        .l_ce_n      (l_ce_n),
        .r_ce_n      (r_ce_n),
        .l_addr      (l_addr),
        .r_addr      (r_addr),
        .l_settled   (settled_v[0]),
        .r_settled   (settled_v[1]),
        .win         (win),
        .l_busy_q    (l_busy_n),
        .r_busy_q    (r_busy_n)
    );

    // present the per-port permits
    always_comb begin
        l_wr_ok = wr_v[0];
        r_wr_ok = wr_v[1];
    end
endmodule

// File: rtl/dp_contention_arb_chk.sv
// Module: dp_contention_arb_chk
// Checker bound to dp_contention_arb; observes ports only.
module dp_contention_arb_chk #(
    parameter int ADDR_W = 13
) (
    input logic              clk,
    input logic              rst_n,
    input logic              master_mode,
    input logic              l_ce_n,
    input logic [ADDR_W-1:0] l_addr,
    input logic              l_we_n,
    input logic              l_busy_in_n,
    input logic              r_ce_n,
    input logic [ADDR_W-1:0] r_addr,
    input logic              r_we_n,
    input logic              r_busy_in_n,
    input logic              l_busy_n,
    input logic              r_busy_n,
    input logic              l_wr_ok,
    input logic              r_wr_ok
);
    logic match;
    always_comb match = !l_ce_n && !r_ce_n && (l_addr == r_addr);

    // R2
    no_busy_without_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !match |=> (l_busy_n && r_busy_n));
    // R2
    one_loser_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!l_busy_n && !r_busy_n));
    // R5
    release_on_deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (l_ce_n || r_ce_n) |=> (l_busy_n && r_busy_n));
    // R8
    slave_busy_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !master_mode |=> (l_busy_n && r_busy_n));
    // R8
    slave_gate_left_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!master_mode && !l_busy_in_n) |=> !l_wr_ok);
    // R8
    slave_gate_right_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!master_mode && !r_busy_in_n) |=> !r_wr_ok);
    // R7
    left_wr_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (l_ce_n || l_we_n) |=> !l_wr_ok);
    // R7
    right_wr_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_ce_n || r_we_n) |=> !r_wr_ok);
endmodule

bind dp_contention_arb dp_contention_arb_chk #(.ADDR_W(ADDR_W)) chk_i (.*);

// File: tb/dp_contention_arb_tb.sv
// Bench for dp_contention_arb: a behavioural model predicts every output each
// clock; inputs are driven and outputs compared at the falling edge.
module dp_contention_arb_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        master_mode = 1'b1;
    logic        l_ce_n = 1'b1, r_ce_n = 1'b1, l_we_n = 1'b1, r_we_n = 1'b1;
    logic        l_busy_in_n = 1'b1, r_busy_in_n = 1'b1;
    logic [12:0] l_addr = '0, r_addr = '0;
    logic        l_busy_n, r_busy_n, l_wr_ok, r_wr_ok;

    int checks = 0;
    int failures = 0;

    // model state
    int   m_owner = 0;      // 0 none, 1 left, 2 right
    bit   m_tie_left = 0;
    bit   p_lce = 1, p_rce = 1;
    int   p_la = 0, p_ra = 0;
    bit   e_lb = 1, e_rb = 1, e_lw = 0, e_rw = 0;

    always #5 clk = ~clk;

    dp_contention_arb dut_i (
        .clk(clk), .rst_n(rst_n), .master_mode(master_mode),
        .l_ce_n(l_ce_n), .l_addr(l_addr), .l_we_n(l_we_n), .l_busy_in_n(l_busy_in_n),
        .r_ce_n(r_ce_n), .r_addr(r_addr), .r_we_n(r_we_n), .r_busy_in_n(r_busy_in_n),
        .l_busy_n(l_busy_n), .r_busy_n(r_busy_n), .l_wr_ok(l_wr_ok), .r_wr_ok(r_wr_ok)
    );

    task automatic check1(input string tag, input string nm, input bit act, input bit exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, nm, act, exp, $time);
        end
    endtask

    task automatic compare_all(input string tag);
        check1(tag, "l_busy_n", l_busy_n, e_lb);
        check1(tag, "r_busy_n", r_busy_n, e_rb);
        check1(tag, "l_wr_ok", l_wr_ok, e_lw);
        check1(tag, "r_wr_ok", r_wr_ok, e_rw);
    endtask

    // behavioural prediction of the outputs after the next rising edge
    task automatic predict();
        bit match, ls, rs, lose_l, lose_r;
        int w;
        match = !l_ce_n && !r_ce_n && (l_addr == r_addr);
        ls = !l_ce_n && !p_lce && (int'(l_addr) == p_la);
        rs = !r_ce_n && !p_rce && (int'(r_addr) == p_ra);
        if (!match) w = 0;
        else if (m_owner != 0) w = m_owner;
        else if (ls && !rs) w = 1;
        else if (rs && !ls) w = 2;
        else begin
            w = m_tie_left ? 2 : 1;
            m_tie_left = (w == 1);
        end
        m_owner = w;
        e_lb = !(master_mode && w == 2);
        e_rb = !(master_mode && w == 1);
        lose_l = master_mode ? (w == 2) : !l_busy_in_n;
        lose_r = master_mode ? (w == 1) : !r_busy_in_n;
        e_lw = !l_ce_n && !l_we_n && !lose_l;
        e_rw = !r_ce_n && !r_we_n && !lose_r;
        p_lce = l_ce_n; p_rce = r_ce_n;
        p_la = int'(l_addr); p_ra = int'(r_addr);
    endtask

    // one clock: compare previous prediction, apply new inputs, predict
    task automatic step(input string tag, input bit mm,
                        input bit lce, input int la, input bit lwe, input bit lbi,
                        input bit rce, input int ra, input bit rwe, input bit rbi);
        @(negedge clk);
        compare_all(tag);
        master_mode = mm;
        l_ce_n = lce; l_addr = 13'(la); l_we_n = lwe; l_busy_in_n = lbi;
        r_ce_n = rce; r_addr = 13'(ra); r_we_n = rwe; r_busy_in_n = rbi;
        predict();
    endtask

    task automatic idle(input string tag, input int n);
        for (int i = 0; i < n; i++) step(tag, 1, 1, 0, 1, 1, 1, 0, 1, 1);
    endtask

    // watchdog
    initial begin
        #2000000;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        compare_all("R1");
        rst_n = 1'b1;
        step("R1", 1, 1, 0, 1, 1, 1, 0, 1, 1);
        step("R1", 1, 1, 0, 1, 1, 1, 0, 1, 1);

        // R7: lone writer, no contention
        step("R7", 1, 0, 5, 0, 1, 1, 0, 1, 1);
        step("R7", 1, 0, 5, 0, 1, 0, 9, 0, 1);
        step("R7", 1, 0, 5, 1, 1, 0, 9, 0, 1);
        idle("R2", 2);

        // R3: right moves onto left's parked word while writing
        step("R3", 1, 0, 10, 1, 1, 0, 20, 0, 1);
        step("R3", 1, 0, 10, 0, 1, 0, 20, 0, 1);
        step("R3", 1, 0, 10, 0, 1, 0, 10, 0, 1);
        step("R3", 1, 0, 10, 0, 1, 0, 10, 0, 1);
        step("R7", 1, 0, 10, 0, 1, 0, 10, 1, 1);
        // R5: mismatch releases
        step("R5", 1, 0, 10, 0, 1, 0, 11, 0, 1);
        step("R5", 1, 0, 10, 0, 1, 0, 11, 0, 1);
        // R3: left moves onto right's word
        step("R3", 1, 0, 11, 0, 1, 0, 11, 0, 1);
        step("R3", 1, 0, 11, 0, 1, 0, 11, 0, 1);
        idle("R5", 2);

        // R4: left selected first, right select falls at same address
        step("R4", 1, 0, 30, 1, 1, 1, 30, 1, 1);
        step("R4", 1, 0, 30, 1, 1, 0, 30, 0, 1);
        step("R4", 1, 0, 30, 1, 1, 0, 30, 0, 1);
        step("R5", 1, 1, 30, 1, 1, 0, 30, 0, 1);
        step("R5", 1, 1, 30, 1, 1, 0, 30, 0, 1);
        // R4: right already selected, left falls
        step("R4", 1, 0, 30, 0, 1, 0, 30, 0, 1);
        step("R4", 1, 0, 30, 0, 1, 0, 30, 0, 1);
        idle("R5", 2);

        // R6: repeated same-cycle ties alternate
        for (int k = 0; k < 4; k++) begin
            step("R6", 1, 0, 40 + k, 0, 1, 0, 40 + k, 0, 1);
            step("R6", 1, 0, 40 + k, 0, 1, 0, 40 + k, 0, 1);
            idle("R6", 1);
        end
        // R6: tie by address move of both ports in one cycle
        step("R6", 1, 0, 50, 1, 1, 0, 51, 1, 1);
        step("R6", 1, 0, 52, 1, 1, 0, 52, 1, 1);
        step("R6", 1, 0, 52, 1, 1, 0, 52, 1, 1);
        idle("R6", 1);

        // R8: slave mode, contention but outputs idle, gating from inputs
        step("R8", 0, 0, 60, 0, 1, 0, 60, 0, 1);
        step("R8", 0, 0, 60, 0, 0, 0, 60, 0, 1);
        step("R8", 0, 0, 60, 0, 1, 0, 60, 0, 0);
        step("R8", 0, 0, 60, 0, 0, 0, 60, 0, 0);
        step("R8", 0, 0, 60, 0, 1, 0, 60, 0, 1);
        // R2: back to master with the match still present
        step("R2", 1, 0, 60, 0, 1, 0, 60, 0, 1);
        step("R2", 1, 0, 60, 0, 1, 0, 60, 0, 1);
        idle("R2", 3);

        @(negedge clk);
        compare_all("R2");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule